// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block walks a DDR2 SDRAM through its power-up and mode-programming sequence on the command bus, then returns the bus idle with every bank precharged. It starts by itself when the synchronous reset is released. Software can also start it again with a write to the low half of the configuration word. The CAS-latency and write-recovery fields feed the mode register word live, taken at the moment that command is issued. All other mode-word fields are fixed.

The two start paths handle the request queues differently. A reset start flushes them: queued work is thrown away. A software start raises a drain request and holds every command back until the queues report that all outstanding reads and writes have finished. The clock-enable stabilization wait and the minimum spacings after each command kind are parameters. One shared down-counter times every gap, and the bus carries NOP between commands.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst` is high, `q_flush` and `init_busy` are 1 and `ddr_cke` is 0. After release, `q_flush` is 0 from the first edge on, and `ddr_cke` rises exactly CKE_WAIT clock edges after release. No command is ever issued while `ddr_cke` is 0.
- R2: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as NOP 0111, precharge 0010, refresh 0001 and mode-set 0000. The sequence order is: precharge-all, mode-set bank 2, mode-set bank 3, mode-set bank 1, mode-set bank 0 (DLL reset), precharge-all, refresh, refresh, mode-set bank 0, refresh. Precharge-all drives address bit 10 = 1 and bank 0, and refresh drives address 0 and bank 0.
- R3: The next command follows exactly T_RP cycles after a precharge, T_MRD cycles after a mode-set and T_RFC cycles after a refresh. The bus carries NOP in between.
- R4: The bank-0 mode word is bit 12 = 0, bits 11:9 = `cfg_wr_rec`, bit 8 = 1 for the first write and 0 for the second, bit 7 = 0, bits 6:4 = `cfg_cas_lat`, bit 3 = 0 and bits 2:0 = 3'b011.
- R5: The bank-1 word is 13'h0004, which sets only bit 2. The bank-2 and bank-3 words are 0.
- R6: When idle, a `cfg_wr` whose `cfg_be` has bit 0 or bit 1 set starts a sequence. A write with only bits 3:2 set has no effect: there is no command, `init_busy` stays 0 and `init_done` stays 1.
- R7: A software start raises `q_drain_req` on the next edge and keeps `ddr_cke` high with no stabilization wait. No command is issued while `q_drain_req` is 1. Once `q_idle` is seen, the drain request drops, and precharge-all follows on the edge after that.
- R8: `init_busy` rises on a start and falls exactly T_RFC cycles after the final refresh. At that point `init_done` rises. The two are never both 1, and no command appears while the block is not busy.
- R9: A configuration write that arrives while a sequence runs is ignored. The running sequence carries on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard/soft reset; its release starts the sequence |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables of the configuration write |
| cfg_cas_lat | input | 3 | CAS-latency field |
| cfg_wr_rec | input | 3 | Write-recovery field |
| q_idle | input | 1 | Request queues have no outstanding reads or writes |
| q_drain_req | output | 1 | Asks the queues to finish pending work |
| q_flush | output | 1 | Tells the queues to drop their contents |
| init_busy | output | 1 | Sequence in progress |
| init_done | output | 1 | Sequence finished, bus idle |
| ddr_cke | output | 1 | Clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 2 | Bank address |
| ddr_addr | output | ADDR_W | Address / mode word |

## Verification
The sequence runs three times under different conditions. The first run is a reset start, which exercises the stabilization wait. The second is a software start with the queues held busy, which shows the drain gate holding commands back and then releasing them. The third is a software start with the queues already idle. Each run uses different CAS-latency and write-recovery values, so a mode word with fixed or swapped fields shows up. A write with only the upper byte enables, and a write that arrives mid-sequence, show that neither a false start nor a restart takes place. A scoreboard compares every command, bank, address and inter-command gap, and the cycle on which busy falls.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [1:0] {K_PRE, K_MRS, K_REF} kind_e;
  typedef enum logic [1:0] {W_ZERO, W_EMR1, W_MR_DLL, W_MR} word_e;

  typedef struct packed {
    kind_e      kind;
    logic [1:0] bank;
    word_e      word;
  } step_t;

  localparam int NUM_STEPS = 10;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] BUS_NOP = 4'b0111;
  localparam logic [3:0] BUS_PRE = 4'b0010;
  localparam logic [3:0] BUS_REF = 4'b0001;
  localparam logic [3:0] BUS_MRS = 4'b0000;

  function automatic step_t step_info(input logic [3:0] idx);
    step_t s;
    s = '{kind: K_PRE, bank: 2'd0, word: W_ZERO};
    case (idx)
      4'd1: s = '{kind: K_MRS, bank: 2'd2, word: W_ZERO};
      4'd2: s = '{kind: K_MRS, bank: 2'd3, word: W_ZERO};
      4'd3: s = '{kind: K_MRS, bank: 2'd1, word: W_EMR1};
      4'd4: s = '{kind: K_MRS, bank: 2'd0, word: W_MR_DLL};
      4'd6, 4'd7, 4'd9: s = '{kind: K_REF, bank: 2'd0, word: W_ZERO};
      4'd8: s = '{kind: K_MRS, bank: 2'd0, word: W_MR};
      default: s = '{kind: K_PRE, bank: 2'd0, word: W_ZERO};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ddr2_init_words.sv
module ddr2_init_words
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  word_e             sel,
  input  logic [2:0]        cas_lat,
  input  logic [2:0]        wr_rec,
  output logic [ADDR_W-1:0] word
);
  localparam logic [2:0] BL8 = 3'b011;

  logic [12:0] w13;

  always_comb begin
    w13 = 13'd0;
    case (sel)
      W_EMR1:   w13 = 13'h0004;
      W_MR_DLL: w13 = {1'b0, wr_rec, 1'b1, 1'b0, cas_lat, 1'b0, BL8};
      W_MR:     w13 = {1'b0, wr_rec, 1'b0, 1'b0, cas_lat, 1'b0, BL8};
      default:  w13 = 13'd0;
    endcase
    word = '0;
    word[12:0] = w13;
  end

endmodule

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int CW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= CW'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/ddr2_init_trigger.sv
module ddr2_init_trigger #(
  parameter int          BE_W     = 4,
  parameter logic [3:0]  LOW_MASK = 4'b0011
) (
  input  logic            cfg_wr,
  input  logic [BE_W-1:0] cfg_be,
  input  logic            idle,
  output logic            sw_go
);
  assign sw_go = idle && cfg_wr && ((cfg_be & BE_W'(LOW_MASK)) != '0);
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int CKE_WAIT = 20,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_be,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [2:0]        cfg_wr_rec,
  input  logic              q_idle,
  output logic              q_drain_req,
  output logic              q_flush,
  output logic              init_busy,
  output logic              init_done,
  output logic              ddr_cke,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [1:0]        ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr
);
  localparam int M1   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int M2   = (M1 > T_RFC) ? M1 : T_RFC;
  localparam int MAXV = (M2 > CKE_WAIT) ? M2 : CKE_WAIT;
  localparam int CW   = $clog2(MAXV + 1);
  localparam int SW   = $clog2(NUM_STEPS + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_DRAIN, ST_STAB, ST_ISSUE, ST_WAIT} state_e;

  state_e            state;
  logic [SW-1:0]     step;
  logic [3:0]        bus_q;
  logic [1:0]        ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cke_q, busy_q, done_q, flush_q, drain_q;

  step_t             info;
  logic [ADDR_W-1:0] mode_word;
  logic              sw_go;
  logic              tmr_zero;
  logic              tmr_load;
  logic [CW-1:0]     tmr_val;
  logic              last_step;

  assign info      = step_info(4'(step));
  assign last_step = (step == SW'(NUM_STEPS));

  ddr2_init_trigger #(.BE_W(4), .LOW_MASK(4'b0011)) u_trig (
    .cfg_wr (cfg_wr),
    .cfg_be (cfg_be),
    .idle   (state == ST_IDLE),
    .sw_go  (sw_go)
  );

  ddr2_init_words #(.ADDR_W(ADDR_W)) u_words (
    .sel     (info.word),
    .cas_lat (cfg_cas_lat),
    .wr_rec  (cfg_wr_rec),
    .word    (mode_word)
  );

  // Gap after a command = 2 + loaded value (issue edge + zero-detect edge).
  always_comb begin
    tmr_load = (state == ST_ISSUE) && !last_step;
    case (info.kind)
      K_PRE:   tmr_val = CW'(T_RP - 2);
      K_REF:   tmr_val = CW'(T_RFC - 2);
      default: tmr_val = CW'(T_MRD - 2);
    endcase
  end

  ddr2_init_timer #(.CW(CW), .RST_VAL(CKE_WAIT - 1)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_STAB;
      step    <= '0;
      cke_q   <= 1'b0;
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      flush_q <= 1'b1;
      drain_q <= 1'b0;
      bus_q   <= BUS_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
    end else begin
      flush_q <= 1'b0;
      bus_q   <= BUS_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      case (state)
        ST_IDLE: begin
          if (sw_go) begin
            state   <= ST_DRAIN;
            drain_q <= 1'b1;
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
          end
        end
        ST_DRAIN: begin
          if (q_idle) begin
            drain_q <= 1'b0;
            step    <= '0;
            state   <= ST_ISSUE;
          end
        end
        ST_STAB: begin
          if (tmr_zero) begin
            cke_q <= 1'b1;
            step  <= '0;
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (last_step) begin
            state  <= ST_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            case (info.kind)
              K_PRE: begin
                bus_q      <= BUS_PRE;
                addr_q[10] <= 1'b1;
              end
              K_REF: bus_q <= BUS_REF;
              default: begin
                bus_q  <= BUS_MRS;
                ba_q   <= info.bank;
                addr_q <= mode_word;
              end
            endcase
            step  <= step + 1'b1;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tmr_zero) state <= ST_ISSUE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign q_drain_req = drain_q;
  assign q_flush     = flush_q;
  assign init_busy   = busy_q;
  assign init_done   = done_q;
  assign ddr_cke     = cke_q;
  assign ddr_cs_n    = bus_q[3];
  assign ddr_ras_n   = bus_q[2];
  assign ddr_cas_n   = bus_q[1];
  assign ddr_we_n    = bus_q[0];
  assign ddr_ba      = ba_q;
  assign ddr_addr    = addr_q;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              q_drain_req,
  input logic              init_busy,
  input logic              init_done,
  input logic              ddr_cke,
  input logic              ddr_cs_n,
  input logic              ddr_ras_n,
  input logic              ddr_cas_n,
  input logic              ddr_we_n,
  input logic [1:0]        ddr_ba,
  input logic [ADDR_W-1:0] ddr_addr
);
  logic [3:0] bus;
  assign bus = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};

  AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (rst)
    (bus != 4'b0111) |-> ddr_cke); // R1
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
    (bus == 4'b0010) |-> (ddr_addr[10] && ddr_ba == 2'd0)); // R2
  AST_CMD_THEN_NOP: assert property (@(posedge clk) disable iff (rst)
    (bus != 4'b0111) |=> (bus == 4'b0111)); // R3
  AST_MR_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    (bus == 4'b0000 && ddr_ba == 2'd0) |->
      (!ddr_addr[12] && !ddr_addr[7] && ddr_addr[3:0] == 4'b0011)); // R4
  AST_EMR_WORDS: assert property (@(posedge clk) disable iff (rst)
    (bus == 4'b0000 && ddr_ba != 2'd0) |->
      (ddr_addr == ((ddr_ba == 2'd1) ? ADDR_W'(4) : '0))); // R5
  AST_DRAIN_HOLDS_BUS: assert property (@(posedge clk) disable iff (rst)
    q_drain_req |-> (bus == 4'b0111)); // R7
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(init_busy && init_done)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !init_busy |-> (bus == 4'b0111)); // R8

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .q_drain_req (q_drain_req),
  .init_busy   (init_busy),
  .init_done   (init_done),
  .ddr_cke     (ddr_cke),
  .ddr_cs_n    (ddr_cs_n),
  .ddr_ras_n   (ddr_ras_n),
  .ddr_cas_n   (ddr_cas_n),
  .ddr_we_n    (ddr_we_n),
  .ddr_ba      (ddr_ba),
  .ddr_addr    (ddr_addr)
);

// File: tb/ddr2_init_seq_bench.sv
module ddr2_init_seq_bench;
  localparam int AW = 13, CKE_WAIT = 20, T_RP = 3, T_MRD = 2, T_RFC = 8;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [3:0] cfg_be = 4'b0;
  logic [2:0] cas_lat = 3'd4, wr_rec = 3'd3;
  logic q_idle = 1'b1;
  logic drain, flush, busy, done, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int checks = 0, fails = 0, cyc = 0, last_cmd = 0;
  logic prev_busy = 1'b0;

  typedef struct { logic [3:0] c; logic [1:0] b; logic [AW-1:0] a; int gap; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  ddr2_init_seq #(.ADDR_W(AW), .CKE_WAIT(CKE_WAIT), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC)) u_ddr2_init_seq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_cas_lat(cas_lat), .cfg_wr_rec(wr_rec), .q_idle(q_idle),
    .q_drain_req(drain), .q_flush(flush), .init_busy(busy), .init_done(done),
    .ddr_cke(cke), .ddr_cs_n(cs_n), .ddr_ras_n(ras_n), .ddr_cas_n(cas_n),
    .ddr_we_n(we_n), .ddr_ba(ba), .ddr_addr(addr));

  task automatic check(input string req, input logic ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [AW-1:0] mr_word(input logic [2:0] cl, input logic [2:0] wr, input logic dll);
    return {1'b0, wr, dll, 1'b0, cl, 1'b0, 3'b011};
  endfunction

  task automatic push(input logic [3:0] c, input logic [1:0] b, input logic [AW-1:0] a, input int gap);
    exp_t e;
    e.c = c; e.b = b; e.a = a; e.gap = gap;
    q.push_back(e);
  endtask

  // Driver: expected command list per R2-R5
  task automatic push_seq(input logic [2:0] cl, input logic [2:0] wr);
    push(PRE, 2'd0, 13'h0400, 0);
    push(MRS, 2'd2, 13'h0000, T_RP);
    push(MRS, 2'd3, 13'h0000, T_MRD);
    push(MRS, 2'd1, 13'h0004, T_MRD);
    push(MRS, 2'd0, mr_word(cl, wr, 1'b1), T_MRD);
    push(PRE, 2'd0, 13'h0400, T_MRD);
    push(REF, 2'd0, 13'h0000, T_RP);
    push(REF, 2'd0, 13'h0000, T_RFC);
    push(MRS, 2'd0, mr_word(cl, wr, 1'b0), T_RFC);
    push(REF, 2'd0, 13'h0000, T_MRD);
  endtask

  // Monitor
  always @(negedge clk) begin
    logic [3:0] bus;
    exp_t e;
    cyc++;
    bus = {cs_n, ras_n, cas_n, we_n};
    if (!rst) begin
      if (bus != NOP) begin
        check("R1 command with cke low", cke, int'(cke), 1);
        if (q.size() == 0) begin
          check("R6/R9 unexpected command", 1'b0, int'(bus), int'(NOP));
        end else begin
          e = q.pop_front();
          check("R2 command code", bus == e.c, int'(bus), int'(e.c));
          check("R2 bank", ba == e.b, int'(ba), int'(e.b));
          check("R4/R5 address word", addr == e.a, int'(addr), int'(e.a));
          if (e.gap != 0)
            check("R3 command spacing", (cyc - last_cmd) == e.gap, cyc - last_cmd, e.gap);
        end
        last_cmd = cyc;
      end
      if (prev_busy && !busy)
        check("R8 busy fall after last refresh", (cyc - last_cmd) == T_RFC, cyc - last_cmd, T_RFC);
    end
    prev_busy = busy;
  end

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done && !busy) break;
    end
  endtask

  task automatic cfg_write(input logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset cke", cke == 1'b0, int'(cke), 0);
    check("R1 reset flush", flush == 1'b1, int'(flush), 1);
    check("R1 reset busy", busy == 1'b1, int'(busy), 1);
    check("R8 reset done", done == 1'b0, int'(done), 0);

    // Run 1: reset start
    push_seq(3'd4, 3'd3);
    rst = 1'b0;
    begin
      int n;
      n = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        n++;
        if (n == 1) check("R1 flush clears", flush == 1'b0, int'(flush), 0);
        if (cke) break;
      end
      check("R1 cke rise edge", n == CKE_WAIT, n, CKE_WAIT);
    end
    wait_done();
    check("R8 done after run 1", done && !busy, int'(done), 1);
    check("R2 run 1 consumed", q.size() == 0, q.size(), 0);

    // R6: upper byte enables only -> ignored
    cfg_write(4'b1100);
    repeat (20) @(negedge clk);
    check("R6 upper write ignored busy", busy == 1'b0, int'(busy), 0);
    check("R6 upper write ignored done", done == 1'b1, int'(done), 1);
    check("R6 upper write ignored drain", drain == 1'b0, int'(drain), 0);

    // Run 2: software start with queues busy
    q_idle = 1'b0;
    cas_lat = 3'd5; wr_rec = 3'd6;
    push_seq(3'd5, 3'd6);
    cfg_write(4'b0001);
    check("R7 drain raised", drain == 1'b1, int'(drain), 1);
    check("R8 busy on start", busy == 1'b1 && done == 1'b0, int'(busy), 1);
    repeat (30) @(negedge clk);
    check("R7 drain held", drain == 1'b1, int'(drain), 1);
    check("R7 cke stays high", cke == 1'b1, int'(cke), 1);
    check("R7 nothing issued while draining", q.size() == 10, q.size(), 10);
    q_idle = 1'b1;
    @(negedge clk);
    check("R7 drain drops", drain == 1'b0, int'(drain), 0);
    @(negedge clk);
    check("R7 precharge right after drain", {cs_n, ras_n, cas_n, we_n} == PRE, int'({cs_n, ras_n, cas_n, we_n}), int'(PRE));
    repeat (12) @(negedge clk);
    cfg_write(4'b0011); // R9: ignored mid-sequence
    wait_done();
    check("R9 run 2 consumed once", q.size() == 0, q.size(), 0);
    repeat (10) @(negedge clk);
    check("R9 no restart", busy == 1'b0 && done == 1'b1, int'(busy), 0);

    // Run 3: software start, queues idle, byte 1 only
    cas_lat = 3'd2; wr_rec = 3'd1;
    push_seq(3'd2, 3'd1);
    cfg_write(4'b0010);
    check("R6 byte1 starts", busy == 1'b1, int'(busy), 1);
    wait_done();
    check("R8 done after run 3", done && !busy, int'(done), 1);
    check("R2 run 3 consumed", q.size() == 0, q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule